// File: doc/BRIEF.md
# Video Timing Reference Monitor

This block watches a parallel 10-bit digital video word stream and takes one word per clock. It finds the four-word timing reference sequences in that stream and drives three qualifiers from them. The first is a horizontal sync qualifier. The second is an ancillary-packet qualifier, which can also flag the sequences themselves. The third is a loss-of-timing flag, and it changes state only after seven consecutive misses or seven consecutive hits.

One mode pin selects the composite or the component reading of the stream. Another pin turns on the sequence indication on the ancillary qualifier. A plain input bus sets the longest line, in clocks, that is still accepted between two sequences. Every output is registered. Each output describes the word that was sampled on the previous clock edge.

Top module: `vid_trs_monitor`

## Requirements
- R1: While the asynchronous active-low reset is held, `notrs_o` is 1 and `hsync_o` and `anc_o` are 0.
- R2: A sequence is recognised only when the input carries 3FF, 000 and 000 on three consecutive clocks. The fourth word, which follows them, is the ID word. Any other pattern (for example 3FF, 000, 040, ID) is not a sequence.
- R3: In composite mode (`cpst_i`=1), `hsync_o` is 1 for exactly the one clock that follows the sampling of each ID word, and 0 at all other times.
- R4: In component mode (`cpst_i`=0), the ID word's bit 6 sets `hsync_o` when it is 1 (EAV) and clears it when it is 0 (SAV). The new value appears on the clock after the ID word. Between sequences, `hsync_o` holds its value.
- R5: An ancillary header is 000, 3FF, 3FF in component mode and the single word 3FC in composite mode. After the header, `anc_o` is 1 for the words data ID, block, count, N payload words and checksum. N is bits [7:0] of the count word, so `anc_o` is high for N+4 clocks. Each clock lags its word by one.
- R6: A count field of 0 makes the checksum follow the count word directly, so `anc_o` is high for exactly 4 clocks.
- R7: A sequence that arrives inside an ancillary packet ends the packet. With `ind_en_i`=0, `anc_o` is 0 on the clock after that sequence's ID word.
- R8: With `ind_en_i`=1, each ID word drives `anc_o` to 1 for 5 clocks in composite mode and for 4 clocks in component mode, starting on the next clock. With `ind_en_i`=0, sequences do not raise `anc_o`.
- R9: A sequence whose ID word comes exactly `max_len_i` clocks after the previous ID word is in time. If it comes one clock later, one miss has been counted before it arrives.
- R10: `notrs_o` rises on the seventh consecutive miss. With no sequence present, a miss is counted every `max_len_i` clocks. Any sequence restarts the miss count.
- R11: `notrs_o` falls on the seventh consecutive in-time sequence. Any miss restarts this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| vid_i | input | 10 | Video word |
| cpst_i | input | 1 | 1: composite reading, 0: component reading |
| ind_en_i | input | 1 | Enables the sequence indication on `anc_o` |
| max_len_i | input | 16 | Longest accepted spacing between ID words, in clocks |
| hsync_o | output | 1 | Horizontal sync qualifier |
| anc_o | output | 1 | Ancillary packet qualifier, optionally also sequence indication |
| notrs_o | output | 1 | Loss-of-timing flag |

## Verification
The bound checker watches the input history on every cycle. It confirms that composite sync equals the "ID word one clock ago" condition and that a component sync edge happens only after a sequence, taking the polarity from bit 6. It also confirms that the loss flag falls only after a sequence, rises only after a clock that carried none, and that an enabled indication always follows an ID word. Other behaviours need scenarios in the bench: the length of a packet qualifier for a given count field, an abort partway through a packet, the exact clock on which the seventh miss or hit takes effect, and the boundary between a spacing of `max_len_i` and `max_len_i`+1.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

  typedef enum logic [2:0] {
    AS_IDLE,
    AS_DID,
    AS_BLK,
    AS_CNT,
    AS_PAY,
    AS_SUM
  } anc_st_e;

  typedef struct packed {
    logic trs;    // current word is the ID word of a sequence
    logic hdr;    // current word completes an ancillary header
    logic h_bit;  // bit 6 of the current word
  } det_t;

endpackage

// File: rtl/vtm_seq_detect.sv
module vtm_seq_detect #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] vid_i,
  input  logic          cpst_i,
  output vtm_pkg::det_t det_o
);
  localparam logic [DW-1:0] W_ONES = '1;
  localparam logic [DW-1:0] W_ZERO = '0;
  localparam logic [DW-1:0] W_ADF  = W_ONES - DW'(3);
  localparam int            HD     = 3;

  // index 0 is the newest past word
  logic [HD-1:0][DW-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = {hist_q[HD-2:0], vid_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    det_o.trs   = (hist_q[2] == W_ONES) && (hist_q[1] == W_ZERO) && (hist_q[0] == W_ZERO);
    det_o.hdr   = cpst_i ? (vid_i == W_ADF)
                         : ((hist_q[1] == W_ZERO) && (hist_q[0] == W_ONES) && (vid_i == W_ONES));
    det_o.h_bit = vid_i[6];
  end

endmodule

// File: rtl/vtm_anc_track.sv
module vtm_anc_track #(
  parameter int DCW      = 8,
  parameter int IND_CPST = 5,
  parameter int IND_CMPT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DCW-1:0] cnt_word_i,
  input  logic           cpst_i,
  input  logic           ind_en_i,
  input  vtm_pkg::det_t  det_i,
  output logic           anc_o
);
  import vtm_pkg::*;

  localparam int IND_MAX = (IND_CPST > IND_CMPT) ? IND_CPST : IND_CMPT;
  localparam int IW      = $clog2(IND_MAX + 1);

  anc_st_e        st_q, st_d;
  logic [DCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;
  logic           pkt_q, pkt_d;
  logic [IW-1:0]  ind_q, ind_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    pkt_d  = 1'b0;
    if (det_i.trs) begin
      st_d = AS_IDLE;
    end else begin
      case (st_q)
        AS_IDLE: if (det_i.hdr) st_d = AS_DID;
        AS_DID:  begin pkt_d = 1'b1; st_d = AS_BLK; end
        AS_BLK:  begin pkt_d = 1'b1; st_d = AS_CNT; end
        AS_CNT:  begin
          pkt_d  = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = cnt_word_i;
          st_d   = (cnt_word_i == '0) ? AS_SUM : AS_PAY;
        end
        AS_PAY:  begin
          pkt_d  = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
          if (cnt_q == DCW'(1)) st_d = AS_SUM;
        end
        AS_SUM:  begin pkt_d = 1'b1; st_d = AS_IDLE; end
        default: st_d = AS_IDLE;
      endcase
    end
  end

  always_comb begin
    if (det_i.trs && ind_en_i) ind_d = cpst_i ? IW'(IND_CPST) : IW'(IND_CMPT);
    else if (ind_q != '0)      ind_d = ind_q - 1'b1;
    else                       ind_d = ind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AS_IDLE;
      pkt_q <= 1'b0;
      ind_q <= '0;
    end else begin
      st_q  <= st_d;
      pkt_q <= pkt_d;
      ind_q <= ind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign anc_o = pkt_q | (ind_q != '0);

endmodule

// File: rtl/vtm_trs_loss.sv
module vtm_trs_loss #(
  parameter int LW   = 16,
  parameter int HYST = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trs_i,
  input  logic [LW-1:0] max_len_i,
  output logic          lost_o
);
  localparam int HW = $clog2(HYST + 1);

  logic [LW-1:0] lc_q, lc_d;
  logic [HW-1:0] good_q, good_d, miss_q, miss_d;
  logic          lost_q, lost_d;
  logic          tout;

  always_comb begin
    tout   = !trs_i && (lc_q == max_len_i - 1'b1);
    lc_d   = lc_q + 1'b1;
    good_d = good_q;
    miss_d = miss_q;
    lost_d = lost_q;
    if (trs_i) begin
      lc_d   = '0;
      miss_d = '0;
      good_d = (good_q == HW'(HYST)) ? good_q : good_q + 1'b1;
      if (good_d == HW'(HYST)) lost_d = 1'b0;
    end else if (tout) begin
      lc_d   = '0;
      good_d = '0;
      miss_d = (miss_q == HW'(HYST)) ? miss_q : miss_q + 1'b1;
      if (miss_d == HW'(HYST)) lost_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q   <= '0;
      good_q <= '0;
      miss_q <= '0;
      lost_q <= 1'b1;
    end else begin
      lc_q   <= lc_d;
      good_q <= good_d;
      miss_q <= miss_d;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;

endmodule

// File: rtl/vid_trs_monitor.sv
module vid_trs_monitor #(
  parameter int DW       = 10,
  parameter int LW       = 16,
  parameter int DCW      = 8,
  parameter int HYST     = 7,
  parameter int IND_CPST = 5,
  parameter int IND_CMPT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] vid_i,
  input  logic          cpst_i,
  input  logic          ind_en_i,
  input  logic [LW-1:0] max_len_i,
  output logic          hsync_o,
  output logic          anc_o,
  output logic          notrs_o
);
  import vtm_pkg::*;

  det_t det;
  logic hs_q, hs_d;

  vtm_seq_detect #(.DW(DW)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .vid_i  (vid_i),
    .cpst_i (cpst_i),
    .det_o  (det)
  );

  vtm_anc_track #(.DCW(DCW), .IND_CPST(IND_CPST), .IND_CMPT(IND_CMPT)) u_anc (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_word_i (vid_i[DCW-1:0]),
    .cpst_i     (cpst_i),
    .ind_en_i   (ind_en_i),
    .det_i      (det),
    .anc_o      (anc_o)
  );

  vtm_trs_loss #(.LW(LW), .HYST(HYST)) u_loss (
    .clk       (clk),
    .rst_n     (rst_n),
    .trs_i     (det.trs),
    .max_len_i (max_len_i),
    .lost_o    (notrs_o)
  );

  always_comb begin
    if (cpst_i)       hs_d = det.trs;
    else if (det.trs) hs_d = det.h_bit;
    else              hs_d = hs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= hs_d;
  end

  assign hsync_o = hs_q;

endmodule

// File: rtl/vtm_checker.sv
module vtm_checker #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] vid_i,
  input logic          cpst_i,
  input logic          ind_en_i,
  input logic          hsync_o,
  input logic          anc_o,
  input logic          notrs_o
);
  localparam logic [DW-1:0] C_ONES = '1;
  localparam logic [DW-1:0] C_ZERO = '0;

  logic [2:0] age_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd7)  age_q <= age_q + 1'b1;
  end
  assign armed = (age_q >= 3'd5);

  p_cpst_hsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cpst_i)) |->
      (hsync_o == (($past(vid_i,4) == C_ONES) && ($past(vid_i,3) == C_ZERO) && ($past(vid_i,2) == C_ZERO))));

  p_cmpt_hsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cpst_i) && !$stable(hsync_o)) |->
      (($past(vid_i,4) == C_ONES) && ($past(vid_i,3) == C_ZERO) && ($past(vid_i,2) == C_ZERO)
       && (hsync_o == $past(vid_i[6]))));

  p_ind_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ind_en_i) && ($past(vid_i,4) == C_ONES) && ($past(vid_i,3) == C_ZERO)
     && ($past(vid_i,2) == C_ZERO)) |-> anc_o);

  p_lost_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(notrs_o)) |->
      !(($past(vid_i,4) == C_ONES) && ($past(vid_i,3) == C_ZERO) && ($past(vid_i,2) == C_ZERO)));

  p_lost_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(notrs_o)) |->
      (($past(vid_i,4) == C_ONES) && ($past(vid_i,3) == C_ZERO) && ($past(vid_i,2) == C_ZERO)));

endmodule

bind vid_trs_monitor vtm_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vid_i    (vid_i),
  .cpst_i   (cpst_i),
  .ind_en_i (ind_en_i),
  .hsync_o  (hsync_o),
  .anc_o    (anc_o),
  .notrs_o  (notrs_o)
);

// File: tb/sim_vid_trs_monitor.sv
`timescale 1ns/1ps
module sim_vid_trs_monitor;
  localparam int DW = 10;
  localparam int LW = 16;
  localparam int ML = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] vid;
  logic          cpst, ind_en;
  logic [LW-1:0] max_len;
  logic          hsync, anc, notrs;

  vid_trs_monitor u0 (
    .clk(clk), .rst_n(rst_n), .vid_i(vid), .cpst_i(cpst), .ind_en_i(ind_en),
    .max_len_i(max_len), .hsync_o(hsync), .anc_o(anc), .notrs_o(notrs)
  );

  int checks = 0, fails = 0;
  bit run_cmp = 0, done = 0;
  int anc_hi = 0;

  // behavioural reference
  int  hist[$];
  int  w, ph, left, tc, lc, good, miss;
  bit  trs, hdr, e_hs, e_pkt, e_anc, e_lost;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      e_hs = 0; e_pkt = 0; e_anc = 0; e_lost = 1;
      ph = 0; left = 0; tc = 0; lc = 0; good = 0; miss = 0;
    end else begin
      w   = int'(vid);
      trs = (hist[0] == 1023) && (hist[1] == 0) && (hist[2] == 0);
      hdr = cpst ? (w == 1020) : ((hist[1] == 0) && (hist[2] == 1023) && (w == 1023));
      if (cpst)     e_hs = trs;
      else if (trs) e_hs = w[6];
      if (trs) begin ph = 0; e_pkt = 0; end
      else begin
        case (ph)
          0: begin e_pkt = 0; if (hdr) ph = 1; end
          1: begin e_pkt = 1; ph = 2; end
          2: begin e_pkt = 1; ph = 3; end
          3: begin e_pkt = 1; left = w & 255; ph = (left == 0) ? 5 : 4; end
          4: begin e_pkt = 1; left--; if (left == 0) ph = 5; end
          default: begin e_pkt = 1; ph = 0; end
        endcase
      end
      if (trs && ind_en) tc = cpst ? 5 : 4;
      else if (tc > 0)   tc--;
      e_anc = e_pkt || (tc > 0);
      if (trs) begin
        lc = 0; miss = 0;
        if (good < 7) good++;
        if (good == 7) e_lost = 0;
      end else if (lc == int'(max_len) - 1) begin
        lc = 0; good = 0;
        if (miss < 7) miss++;
        if (miss == 7) e_lost = 1;
      end else lc++;
      hist.push_back(w);
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk(cpst ? "R3 hsync" : "R4 hsync", int'(hsync), int'(e_hs));
      chk("R5 anc", int'(anc), int'(e_anc));
      chk("R10 notrs", int'(notrs), int'(e_lost));
    end
    if (anc) anc_hi++;
  end

  task automatic put(input int x);
    vid = x[DW-1:0];
    @(negedge clk);
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) put(10'h040);
  endtask

  task automatic seq(input int id);
    put(10'h3FF); put(0); put(0); put(id);
  endtask

  task automatic header();
    if (cpst) put(10'h3FC);
    else begin put(0); put(10'h3FF); put(10'h3FF); end
  endtask

  task automatic pkt(input int n);
    header();
    put(10'h141); put(10'h101); put(n);
    for (int i = 0; i < n; i++) put(10'h080 + i);
    put(10'h0AA);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; vid = 10'h040; cpst = 0; ind_en = 0; max_len = LW'(ML);
    repeat (3) @(negedge clk);
    chk("R1 notrs in reset", int'(notrs), 1);
    chk("R1 hsync in reset", int'(hsync), 0);
    chk("R1 anc in reset", int'(anc), 0);
    rst_n = 1; run_cmp = 1;

    // component lines: EAV, packet, SAV; loss flag clears on 7th sequence
    for (int k = 1; k <= 8; k++) begin
      seq(10'h274);
      chk("R4 EAV sets hsync", int'(hsync), 1);
      chk("R11 clear on 7th hit", int'(notrs), (2 * k - 1 < 7) ? 1 : 0);
      fill(10);
      anc_hi = 0; pkt(3); #1;
      chk("R5 packet length N=3", anc_hi, 7);
      seq(10'h200);
      chk("R4 SAV clears hsync", int'(hsync), 0);
      fill(20);
    end

    // near miss is not a sequence
    put(10'h3FF); put(0); put(10'h040); put(10'h274);
    chk("R2 near miss ignored", int'(hsync), 0);

    // zero count
    seq(10'h274); fill(2);
    anc_hi = 0; pkt(0); #1;
    chk("R6 zero count length", anc_hi, 4);
    seq(10'h200); fill(2);

    // abort inside a packet
    header(); put(10'h141); put(10'h101); put(20); put(10'h080); put(10'h081);
    chk("R7 inside packet", int'(anc), 1);
    seq(10'h274);
    chk("R7 sequence aborts packet", int'(anc), 0);
    fill(5);

    // indication in component mode
    ind_en = 1;
    anc_hi = 0; seq(10'h200); fill(10); #1;
    chk("R8 component indication length", anc_hi, 4);

    // composite mode
    cpst = 1;
    anc_hi = 0; seq(10'h2A0);
    chk("R3 composite pulse high", int'(hsync), 1);
    put(10'h040);
    chk("R3 composite pulse one clock", int'(hsync), 0);
    fill(10); #1;
    chk("R8 composite indication length", anc_hi, 5);
    ind_en = 0;
    fill(2);
    anc_hi = 0; pkt(2); #1;
    chk("R5 composite packet N=2", anc_hi, 6);
    anc_hi = 0; seq(10'h2A0); fill(6); #1;
    chk("R8 indication off", anc_hi, 0);
    fill(10);
    cpst = 0;

    // late lines: misses never reach seven in a row
    for (int k = 0; k < 10; k++) begin seq(10'h274); fill(ML + 1 - 4); end
    chk("R10 isolated misses keep flag low", int'(notrs), 0);
    seq(10'h274);
    fill(7 * ML - 1);
    chk("R10 six misses flag low", int'(notrs), 0);
    put(10'h040);
    chk("R10 seventh miss sets flag", int'(notrs), 1);

    // late lines cannot clear, exact spacing can
    for (int k = 0; k < 10; k++) begin
      seq(10'h274); fill(ML + 1 - 4);
      chk("R9 spacing max_len+1 is late", int'(notrs), 1);
    end
    for (int k = 1; k <= 8; k++) begin
      seq(10'h274);
      chk("R9 spacing max_len in time", int'(notrs), (k < 7) ? 1 : 0);
      fill(ML - 4);
    end

    fill(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule